// File: doc/BRIEF.md
# Blocking Neighbour Port with Instruction Fetch

This block is the synchronous model of a point-to-point link between two adjacent processor cores. Words are 18 bits wide. The port holds no storage. A transfer happens only in the cycle where a sender offers a word and a receiver asks for one. Until then the side that is waiting sees its stall output high, which the core uses to sleep.

On the receive side the core can ask for a word in two ways. A data read delivers the word into a result register. An instruction fetch splits the word into a group of four instruction slots for the decoder. On the send side the core offers a word and stalls until the downstream neighbour accepts it. A pass-through mode connects the incoming link straight to the outgoing link. In that mode the incoming word is acknowledged only when the downstream side accepts it, and nothing is captured locally.

Top module: `nbr_link`

## Requirements
- R1: While `fwd_en` is low and a read or fetch is requested, `rx_ready` is high and `rd_stall` equals the inverse of `rx_valid`. The transfer completes in the cycle where both are high, and `rd_stall` drops in that same cycle.
- R2: A completed data read loads `rx_data` into `rd_word` at that clock edge and raises `rd_word_vld` for exactly the next cycle. At every other time `rd_word` keeps its value.
- R3: While `fwd_en` is low and `core_wr_req` is high, `tx_valid` is high, `tx_data` equals `core_wr_data`, and `wr_stall` is high exactly while `tx_ready` is low.
- R4: A completed fetch raises `ins_vld` for the next cycle and leaves `rd_word` unchanged. `ins_slots` then holds the word split from the most significant end: bits [19:15] take word[17:13], bits [14:10] take word[12:8], bits [9:5] take word[7:3], and bits [4:0] take {2'b00, word[2:0]}.
- R5: When read and fetch are requested together, the transfer is treated as a fetch: `ins_vld` is raised and `rd_word_vld` is not.
- R6: There is no buffering. With no read or fetch requested and `fwd_en` low, `rx_ready` is low and an offered word is not kept. A later read after `rx_valid` has dropped stays stalled.
- R7: While `fwd_en` is high, `tx_valid` follows `rx_valid`, `tx_data` follows `rx_data`, and `rx_ready` follows `tx_ready`. Neither `rd_word_vld` nor `ins_vld` is raised, and `rd_word` is unchanged.
- R8: While `fwd_en` is high, a core read or fetch request keeps `rd_stall` high and a core write request keeps `wr_stall` high.
- R9: After reset `rd_word` and `ins_slots` are zero, and `rd_word_vld` and `ins_vld` are low.
- R10: A data read and a core write can complete in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fwd_en | input | 1 | Pass-through mode: incoming link drives outgoing link |
| rx_valid | input | 1 | Upstream neighbour offers a word |
| rx_data | input | 18 | Offered word from upstream |
| rx_ready | output | 1 | Acknowledge to upstream; transfer in when both high |
| tx_valid | output | 1 | Word offered to downstream neighbour |
| tx_data | output | 18 | Word offered downstream |
| tx_ready | input | 1 | Downstream neighbour accepts |
| core_rd_req | input | 1 | Core asks for a data word |
| core_fetch_req | input | 1 | Core asks for an instruction word |
| core_wr_req | input | 1 | Core offers a word downstream |
| core_wr_data | input | 18 | Word the core sends |
| rd_stall | output | 1 | Core read or fetch is waiting |
| wr_stall | output | 1 | Core write is waiting |
| rd_word | output | 18 | Last word delivered by a data read |
| rd_word_vld | output | 1 | One-cycle pulse after a data read completes |
| ins_slots | output | 20 | Four 5-bit instruction slots from the last fetch |
| ins_vld | output | 1 | One-cycle pulse after a fetch completes |

## Verification
The hardest case to reach from the ports is proving that nothing is buffered. A word that is offered and then withdrawn leaves no mark on any output by itself. The stimulus therefore offers a word for several cycles with no taker, removes it, and then raises a read. That read must stay stalled and must not change `rd_word`, which shows the withdrawn word was never held. Pass-through is handled in a similar way: the bench holds back downstream acceptance while a core read is pending, then checks that the forwarded word never reaches the local result registers.

// File: rtl/nbr_link_pkg.sv
// Shared widths and types for the neighbour link.
// Assumes one incoming and one outgoing link per port instance.
package nbr_link_pkg;
    localparam int NL_WORD_W = 18;
    localparam int NL_SLOT_W = 5;
    localparam int NL_SLOTS  = 4;

    // Which kind of local receive completed in the current cycle.
    typedef struct packed {
        logic rd;
        logic fetch;
    } take_t;
endpackage

// File: rtl/nbr_link_join.sv
// Rendezvous steering for both link directions.
// Purely combinational: a transfer fires in the cycle where offer and
// request meet. Pass-through mode ties the two links together and holds
// every core request stalled. Fetch wins over read when both are asked.
module nbr_link_join
    import nbr_link_pkg::*;
#(
    parameter int WORD_W = NL_WORD_W
) (
    input  logic              fwd_en,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              tx_ready,
    input  logic              core_rd_req,
    input  logic              core_fetch_req,
    input  logic              core_wr_req,
    input  logic [WORD_W-1:0] core_wr_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    output logic              rd_stall,
    output logic              wr_stall,
    output take_t             take
);
    logic want_rx;
    logic local_fire;

    // Receive side: who takes the incoming word and whether it completes.
    always_comb begin
        want_rx    = core_rd_req | core_fetch_req;
        rx_ready   = fwd_en ? tx_ready : want_rx;
        local_fire = !fwd_en && want_rx && rx_valid;
        take.fetch = local_fire && core_fetch_req;
        take.rd    = local_fire && !core_fetch_req;
        rd_stall   = want_rx && !local_fire;
    end

    // Send side: core word or forwarded word goes out.
    always_comb begin
        tx_valid = fwd_en ? rx_valid : core_wr_req;
        tx_data  = fwd_en ? rx_data  : core_wr_data;
        wr_stall = core_wr_req && (fwd_en || !tx_ready);
    end
endmodule

// File: rtl/nbr_link_unpack.sv
// Splits one word into instruction slots, most significant slot first.
// A final slot narrower than SLOT_W is zero-extended at its top.
// Assumes WORD_W > (SLOTS-1)*SLOT_W so every slot has at least one bit.
module nbr_link_unpack #(
    parameter int WORD_W = 18,
    parameter int SLOT_W = 5,
    parameter int SLOTS  = 4,
    localparam int GRP_W = SLOT_W * SLOTS
) (
    input  logic [WORD_W-1:0] word,
    output logic [GRP_W-1:0]  slots
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam int HI = WORD_W - 1 - i * SLOT_W;
        localparam int LO = WORD_W - (i + 1) * SLOT_W;
        localparam int OB = (SLOTS - 1 - i) * SLOT_W;
        if (LO >= 0) begin : g_full
            // Full-width slot taken straight from the word.
            assign slots[OB +: SLOT_W] = word[HI:LO];
        end else begin : g_short
            // Short tail slot padded with zeros on the left.
            assign slots[OB +: SLOT_W] = SLOT_W'(word[HI:0]);
        end
    end
endmodule

// File: rtl/nbr_link_sink.sv
// Local capture registers for completed receives.
// A data read loads the result word. A fetch loads the unpacked slots.
// Each raises a one-cycle strobe. Synchronous active-low reset.
module nbr_link_sink
    import nbr_link_pkg::*;
#(
    parameter int WORD_W = NL_WORD_W,
    parameter int SLOT_W = NL_SLOT_W,
    parameter int SLOTS  = NL_SLOTS,
    localparam int GRP_W = SLOT_W * SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  take_t             take,
    input  logic [WORD_W-1:0] rx_data,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_word_vld,
    output logic [GRP_W-1:0]  ins_slots,
    output logic              ins_vld
);
    logic [GRP_W-1:0] split;

    nbr_link_unpack #(
        .WORD_W(WORD_W),
        .SLOT_W(SLOT_W),
        .SLOTS (SLOTS)
    ) u_unpack (
        .word (rx_data),
        .slots(split)
    );

    // Data read result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word     <= '0;
            rd_word_vld <= 1'b0;
        end else begin
            rd_word_vld <= take.rd;
            if (take.rd) rd_word <= rx_data;
        end
    end

    // Instruction group from a fetch and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_slots <= '0;
            ins_vld   <= 1'b0;
        end else begin
            ins_vld <= take.fetch;
            if (take.fetch) ins_slots <= split;
        end
    end
endmodule

// File: rtl/nbr_link.sv
// Blocking neighbour port: zero-storage rendezvous on an incoming and an
// outgoing link. Incoming words are read as data, fetched as instruction
// groups, or forwarded out unchanged. Stalls are combinational and drop in
// the cycle the transfer completes.
module nbr_link
    import nbr_link_pkg::*;
#(
    parameter int WORD_W = NL_WORD_W,
    parameter int SLOT_W = NL_SLOT_W,
    parameter int SLOTS  = NL_SLOTS,
    localparam int GRP_W = SLOT_W * SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd_en,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              core_rd_req,
    input  logic              core_fetch_req,
    input  logic              core_wr_req,
    input  logic [WORD_W-1:0] core_wr_data,
    output logic              rd_stall,
    output logic              wr_stall,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_word_vld,
    output logic [GRP_W-1:0]  ins_slots,
    output logic              ins_vld
);
    take_t take;

    nbr_link_join #(.WORD_W(WORD_W)) u_join (
        .fwd_en        (fwd_en),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .tx_ready      (tx_ready),
        .core_rd_req   (core_rd_req),
        .core_fetch_req(core_fetch_req),
        .core_wr_req   (core_wr_req),
        .core_wr_data  (core_wr_data),
        .rx_ready      (rx_ready),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .rd_stall      (rd_stall),
        .wr_stall      (wr_stall),
        .take          (take)
    );

    nbr_link_sink #(
        .WORD_W(WORD_W),
        .SLOT_W(SLOT_W),
        .SLOTS (SLOTS)
    ) u_sink (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .rx_data    (rx_data),
        .rd_word    (rd_word),
        .rd_word_vld(rd_word_vld),
        .ins_slots  (ins_slots),
        .ins_vld    (ins_vld)
    );
endmodule

// File: rtl/nbr_link_chk.sv
// Protocol checker for nbr_link, attached by bind below.
// Observes only the port-level behaviour of the block.
module nbr_link_chk #(
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fwd_en,
    input logic              rx_valid,
    input logic [WORD_W-1:0] rx_data,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [WORD_W-1:0] tx_data,
    input logic              tx_ready,
    input logic              core_rd_req,
    input logic              core_fetch_req,
    input logic              core_wr_req,
    input logic [WORD_W-1:0] core_wr_data,
    input logic              rd_stall,
    input logic              wr_stall,
    input logic [WORD_W-1:0] rd_word,
    input logic              rd_word_vld,
    input logic              ins_vld
);
    a_r1_rd_meet: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_en && (core_rd_req || core_fetch_req)) |-> (rx_ready && (rd_stall == !rx_valid)));

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_en && core_rd_req && !core_fetch_req && rx_valid)
        |=> (rd_word_vld && rd_word == $past(rx_data)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_word_vld |-> $stable(rd_word));

    a_r3_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_en && core_wr_req) |-> (tx_valid && tx_data == core_wr_data && (wr_stall == !tx_ready)));

    a_r4_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_en && core_fetch_req && rx_valid) |=> (ins_vld && !rd_word_vld));

    a_r6_no_taker: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_en && !core_rd_req && !core_fetch_req) |-> !rx_ready);

    a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_en |-> (tx_valid == rx_valid && tx_data == rx_data && rx_ready == tx_ready));

    a_r7_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_en |=> (!rd_word_vld && !ins_vld));

    a_r8_core_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && (core_rd_req || core_fetch_req || core_wr_req))
        |-> ((rd_stall || !(core_rd_req || core_fetch_req)) && (wr_stall || !core_wr_req)));
endmodule

bind nbr_link nbr_link_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_nbr_link.sv
`timescale 1ns/1ps
module sim_nbr_link;
    localparam int W = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwd_en = 1'b0, rx_valid = 1'b0, tx_ready = 1'b0;
    logic          core_rd_req = 1'b0, core_fetch_req = 1'b0, core_wr_req = 1'b0;
    logic [W-1:0]  rx_data = '0, core_wr_data = '0;
    logic          rx_ready, tx_valid, rd_stall, wr_stall, rd_word_vld, ins_vld;
    logic [W-1:0]  tx_data, rd_word;
    logic [19:0]   ins_slots;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] last_rd = '0;

    nbr_link u0 (.*);

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic         fwd, rd, fe, wr, rxv, txr;
        logic [W-1:0] rxd, wrd;
        logic         e_rxr, e_txv, e_rds, e_wrs, e_rdv, e_insv;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 13;
    // fwd rd fe wr rxv txr | rxd wrd | rxr txv rds wrs rdv insv | req
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,0,0, 18'h00000, 18'h00000, 0,0,0,0,0,0, 4'd6},  // R6 idle
        '{0,1,0,0,0,0, 18'h00000, 18'h00000, 1,0,1,0,0,0, 4'd1},  // R1 read waits
        '{0,1,0,0,1,0, 18'h2A5F3, 18'h00000, 1,0,0,0,1,0, 4'd2},  // R2 read meets
        '{0,0,0,0,1,0, 18'h15555, 18'h00000, 0,0,0,0,0,0, 4'd6},  // R6 no taker
        '{0,0,0,1,0,0, 18'h00000, 18'h0BEEF, 0,1,0,1,0,0, 4'd3},  // R3 write waits
        '{0,0,0,1,0,1, 18'h00000, 18'h3C0DE, 0,1,0,0,0,0, 4'd3},  // R3 write meets
        '{0,0,1,0,0,0, 18'h00000, 18'h00000, 1,0,1,0,0,0, 4'd1},  // R1 fetch waits
        '{0,0,1,0,1,0, 18'h1B3C6, 18'h00000, 1,0,0,0,0,1, 4'd4},  // R4 fetch meets
        '{0,1,1,0,1,0, 18'h0F0F0, 18'h00000, 1,0,0,0,0,1, 4'd5},  // R5 both asked
        '{1,0,0,0,1,0, 18'h12345, 18'h00000, 0,1,0,0,0,0, 4'd7},  // R7 fwd held
        '{1,0,0,0,1,1, 18'h23456, 18'h00000, 1,1,0,0,0,0, 4'd7},  // R7 fwd moves
        '{1,1,0,1,1,1, 18'h34567, 18'h01111, 1,1,1,1,0,0, 4'd8},  // R8 core held
        '{0,1,0,1,1,1, 18'h2D2D2, 18'h1E1E1, 1,1,0,0,1,0, 4'd10}  // R10 concurrent
    };

    function automatic logic [19:0] exp_slots(input logic [W-1:0] d);
        return {d[17:13], d[12:8], d[7:3], 2'b00, d[2:0]};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        fwd_en = 0; core_rd_req = 0; core_fetch_req = 0; core_wr_req = 0;
        rx_valid = 0; tx_ready = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check(rd_word == 0, "R9", "rd_word", 32'(rd_word), 0);
        check(ins_slots == 0, "R9", "ins_slots", 32'(ins_slots), 0);
        check(!rd_word_vld && !ins_vld, "R9", "strobes", {rd_word_vld, ins_vld}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rq;
            v = VECS[i];
            rq = $sformatf("R%0d", v.req);
            fwd_en = v.fwd; core_rd_req = v.rd; core_fetch_req = v.fe;
            core_wr_req = v.wr; rx_valid = v.rxv; tx_ready = v.txr;
            rx_data = v.rxd; core_wr_data = v.wrd;
            #1;
            check(rx_ready == v.e_rxr, rq, "rx_ready", rx_ready, v.e_rxr);
            check(tx_valid == v.e_txv, rq, "tx_valid", tx_valid, v.e_txv);
            check(rd_stall == v.e_rds, rq, "rd_stall", rd_stall, v.e_rds);
            check(wr_stall == v.e_wrs, rq, "wr_stall", wr_stall, v.e_wrs);
            if (v.e_txv)
                check(tx_data == (v.fwd ? v.rxd : v.wrd), rq, "tx_data",
                      32'(tx_data), 32'(v.fwd ? v.rxd : v.wrd));
            @(negedge clk);
            check(rd_word_vld == v.e_rdv, rq, "rd_word_vld", rd_word_vld, v.e_rdv);
            check(ins_vld == v.e_insv, rq, "ins_vld", ins_vld, v.e_insv);
            if (v.e_rdv) last_rd = v.rxd;
            check(rd_word == last_rd, rq, "rd_word", 32'(rd_word), 32'(last_rd));
            if (v.e_insv)
                check(ins_slots == exp_slots(v.rxd), rq, "ins_slots",
                      32'(ins_slots), 32'(exp_slots(v.rxd)));
            idle();
        end

        // R6: a word offered with no taker, then withdrawn, is not kept
        rx_valid = 1; rx_data = 18'h30F0F;
        for (int k = 0; k < 2; k++) begin
            #1 check(!rx_ready, "R6", "rx_ready no taker", rx_ready, 0);
            @(negedge clk);
        end
        rx_valid = 0; core_rd_req = 1;
        for (int k = 0; k < 3; k++) begin
            #1 check(rd_stall, "R6", "read after withdraw", rd_stall, 1);
            @(negedge clk);
            check(!rd_word_vld && rd_word == last_rd, "R2", "rd_word hold",
                  32'(rd_word), 32'(last_rd));
        end
        // R1: the waiting read completes once the word arrives
        rx_valid = 1; rx_data = 18'h0ACE1;
        #1 check(!rd_stall, "R1", "stall drops on meet", rd_stall, 0);
        @(negedge clk);
        last_rd = 18'h0ACE1;
        check(rd_word_vld && rd_word == last_rd, "R2", "late read word",
              32'(rd_word), 32'(last_rd));
        idle();

        // R4: all-ones boundary word; fetch leaves rd_word alone
        core_fetch_req = 1; rx_valid = 1; rx_data = 18'h3FFFF;
        @(negedge clk);
        check(ins_slots == 20'hFFFE7, "R4", "slots all ones", 32'(ins_slots), 32'h FFFE7);
        check(rd_word == last_rd, "R4", "rd_word after fetch", 32'(rd_word), 32'(last_rd));
        idle();

        // R7: forwarding held back downstream, then released; nothing stored
        fwd_en = 1; rx_valid = 1; rx_data = 18'h2B2B2; core_rd_req = 1;
        for (int k = 0; k < 2; k++) begin
            #1 check(!rx_ready && tx_data == 18'h2B2B2, "R7", "held forward",
                     32'(tx_data), 32'h2B2B2);
            check(rd_stall, "R8", "read held in fwd", rd_stall, 1);
            @(negedge clk);
        end
        tx_ready = 1;
        #1 check(rx_ready, "R7", "forward ack", rx_ready, 1);
        @(negedge clk);
        check(!rd_word_vld && !ins_vld && rd_word == last_rd, "R7", "no local store",
              32'(rd_word), 32'(last_rd));
        idle();
        @(negedge clk);
        finish_run();
    end
endmodule